// File: doc/BRIEF.md
# Pipelined Unrounded Single-Precision Multiplier

This block multiplies two normalized single-precision binary floating-point operands and delivers the product without any rounding. The sign, the biased exponent and the 24-bit by 24-bit significand product are formed side by side. The 48-bit product is then normalized by at most one position, and the whole product below the hidden one is kept as a 47-bit fraction. A downstream adder, as in a multiply-accumulate loop, therefore receives every product bit.

The result leaves through three register stages. A valid bit travels with each operand pair, and a new pair may enter on every clock. A result whose exponent falls outside the normal range is replaced by a flagged, saturated code. Operands with an exponent field of 0 or 255 are outside the supported domain, and the block gives no defined result for them.

Top module: `fpm_top`

## Requirements
- R1: `res_sign` equals the XOR of bit 31 of the two operands.
- R2: When bit 47 of the significand product is clear, bit 46 holds the leading one. The fraction is then product bits 45..0 with a zero appended as its least significant bit, and the exponent is not adjusted.
- R3: When bit 47 of the significand product is set, the fraction is product bits 46..0 and the exponent is one higher than the unadjusted value.
- R4: Before normalization, the result exponent is the sum of the two 8-bit exponent fields (bits 30..23) minus 127.
- R5: If the normalized exponent is below 1, `res_unf` is 1, `res_ovf` is 0, and both `res_exp` and `res_frac` are 0.
- R6: If the normalized exponent is above 254, `res_ovf` is 1, `res_unf` is 0, `res_exp` is 255 and `res_frac` is 0.
- R7: A pair accepted with `in_valid` high at a clock edge produces its result, with `res_valid` high, after the third rising edge counted from that edge. Pairs may be applied on consecutive cycles. A cycle with `in_valid` low produces a cycle with `res_valid` low.
- R8: While `rst` is high at a rising edge, every output register is cleared to 0.
- R9: No rounding or truncation is applied. All 47 fraction bits are exact product bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present |
| op_a | input | 32 | First operand: sign in bit 31, exponent in 30..23, fraction in 22..0 |
| op_b | input | 32 | Second operand, same layout |
| res_valid | output | 1 | Result present |
| res_sign | output | 1 | Product sign |
| res_exp | output | 8 | Biased product exponent |
| res_frac | output | 47 | Unrounded fraction below the hidden one |
| res_ovf | output | 1 | Exponent overflow |
| res_unf | output | 1 | Exponent underflow |

## Verification
Corrupted partial-product slices or a wrong slice offset in the merge stage show up as wrong `res_frac` bits exactly three cycles after the affected pair. Wide operand fractions expose them quickly. A wrong normalization decision shows as an exponent off by one together with a fraction shifted by one bit. The directed cases at exponent sums of 0, 127, 254 and 255 separate a wrong bias constant, a wrong range limit and flag priority. A dropped or doubled pipeline stage misaligns `res_valid` against the bubble pattern on the very next result.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int OFRAC_W = PROD_W - 1;
    localparam int XE_W    = EXP_W + 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX    = (1 << EXP_W) - 2;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic                    valid;
        logic                    sign;
        logic signed [XE_W-1:0]  eint;
        logic [PROD_W-1:0]       prod;
    } mid_stage_t;

    typedef struct packed {
        logic               valid;
        logic               sign;
        logic [EXP_W-1:0]   expo;
        logic [OFRAC_W-1:0] frac;
        logic               ovf;
        logic               unf;
    } result_t;

    function automatic fp_word_t split_word(input logic [WORD_W-1:0] w);
        fp_word_t f;
        f.sign = w[WORD_W-1];
        f.expo = w[WORD_W-2 -: EXP_W];
        f.frac = w[FRAC_W-1:0];
        return f;
    endfunction

    function automatic logic [SIG_W-1:0] with_hidden(input logic [FRAC_W-1:0] f);
        return {1'b1, f};
    endfunction

endpackage

// File: rtl/fpm_slice_mul.sv
module fpm_slice_mul
    import fpm_pkg::*;
#(
    parameter int SLICES = 2,
    localparam int SL_W  = SIG_W / SLICES,
    localparam int PP_W  = SIG_W + SL_W
) (
    input  logic [SIG_W-1:0]            sig_a,
    input  logic [SIG_W-1:0]            sig_b,
    output logic [SLICES-1:0][PP_W-1:0] pp
);
    initial begin
        if (SIG_W % SLICES != 0) $error("slice count must divide significand width");
    end

    for (genvar i = 0; i < SLICES; i++) begin : g_slice
        logic [SL_W-1:0] b_part;
        assign b_part = sig_b[i*SL_W +: SL_W];
        assign pp[i]  = PP_W'(sig_a) * PP_W'(b_part);
    end
endmodule

// File: rtl/fpm_merge.sv
module fpm_merge
    import fpm_pkg::*;
#(
    parameter int SLICES = 2,
    localparam int SL_W  = SIG_W / SLICES,
    localparam int PP_W  = SIG_W + SL_W
) (
    input  logic [SLICES-1:0][PP_W-1:0] pp,
    output logic [PROD_W-1:0]           prod
);
    always_comb begin
        prod = '0;
        for (int i = 0; i < SLICES; i++) begin
            prod = prod + (PROD_W'(pp[i]) << (i * SL_W));
        end
    end
endmodule

// File: rtl/fpm_exp_bias.sv
module fpm_exp_bias
    import fpm_pkg::*;
(
    input  logic [EXP_W:0]          esum,
    output logic signed [XE_W-1:0]  eint
);
    localparam logic signed [XE_W-1:0] BIAS_S = XE_W'(BIAS);

    assign eint = $signed({1'b0, esum}) - BIAS_S;
endmodule

// File: rtl/fpm_normalize.sv
module fpm_normalize
    import fpm_pkg::*;
(
    input  logic [PROD_W-1:0]         prod,
    input  logic signed [XE_W-1:0]    eint,
    output logic [EXP_W-1:0]          expo,
    output logic [OFRAC_W-1:0]        frac,
    output logic                      ovf,
    output logic                      unf
);
    localparam logic signed [XE_W-1:0] LO_S = XE_W'(1);
    localparam logic signed [XE_W-1:0] HI_S = XE_W'(EMAX);

    logic                    top_bit;
    logic signed [XE_W-1:0]  eadj;
    logic [OFRAC_W-1:0]      frac_n;

    assign top_bit = prod[PROD_W-1];
    assign eadj    = eint + (top_bit ? LO_S : '0);
    assign frac_n  = top_bit ? prod[PROD_W-2:0] : {prod[PROD_W-3:0], 1'b0};

    always_comb begin
        unf  = 1'b0;
        ovf  = 1'b0;
        expo = eadj[EXP_W-1:0];
        frac = frac_n;
        if (eadj < LO_S) begin
            unf  = 1'b1;
            expo = '0;
            frac = '0;
        end else if (eadj > HI_S) begin
            ovf  = 1'b1;
            expo = '1;
            frac = '0;
        end
    end
endmodule

// File: rtl/fpm_top.sv
module fpm_top
    import fpm_pkg::*;
#(
    parameter int SLICES = 2,
    localparam int SL_W  = SIG_W / SLICES,
    localparam int PP_W  = SIG_W + SL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [WORD_W-1:0]    op_a,
    input  logic [WORD_W-1:0]    op_b,
    output logic                 res_valid,
    output logic                 res_sign,
    output logic [EXP_W-1:0]     res_exp,
    output logic [OFRAC_W-1:0]   res_frac,
    output logic                 res_ovf,
    output logic                 res_unf
);
    fp_word_t fa, fb;
    assign fa = split_word(op_a);
    assign fb = split_word(op_b);

    // stage 1: partial products, exponent sum, sign
    logic [SLICES-1:0][PP_W-1:0] pp_c, pp_q;
    logic [EXP_W:0]              esum_q;
    logic                        v1_q, s1_q;

    fpm_slice_mul #(.SLICES(SLICES)) u_mul (
        .sig_a (with_hidden(fa.frac)),
        .sig_b (with_hidden(fb.frac)),
        .pp    (pp_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pp_q   <= '0;
            esum_q <= '0;
            v1_q   <= 1'b0;
            s1_q   <= 1'b0;
        end else begin
            pp_q   <= pp_c;
            esum_q <= {1'b0, fa.expo} + {1'b0, fb.expo};
            v1_q   <= in_valid;
            s1_q   <= fa.sign ^ fb.sign;
        end
    end

    // stage 2: merged product, biased exponent
    logic [PROD_W-1:0]       prod_c;
    logic signed [XE_W-1:0]  eint_c;
    mid_stage_t              mid_q;

    fpm_merge #(.SLICES(SLICES)) u_merge (
        .pp   (pp_q),
        .prod (prod_c)
    );

    fpm_exp_bias u_bias (
        .esum (esum_q),
        .eint (eint_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_q <= '0;
        end else begin
            mid_q.valid <= v1_q;
            mid_q.sign  <= s1_q;
            mid_q.eint  <= eint_c;
            mid_q.prod  <= prod_c;
        end
    end

    // stage 3: normalize and range check
    logic [EXP_W-1:0]   n_exp;
    logic [OFRAC_W-1:0] n_frac;
    logic               n_ovf, n_unf;
    result_t            out_q;

    fpm_normalize u_norm (
        .prod (mid_q.prod),
        .eint (mid_q.eint),
        .expo (n_exp),
        .frac (n_frac),
        .ovf  (n_ovf),
        .unf  (n_unf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= mid_q.valid;
            out_q.sign  <= mid_q.sign;
            out_q.expo  <= n_exp;
            out_q.frac  <= n_frac;
            out_q.ovf   <= n_ovf;
            out_q.unf   <= n_unf;
        end
    end

    assign res_valid = out_q.valid;
    assign res_sign  = out_q.sign;
    assign res_exp   = out_q.expo;
    assign res_frac  = out_q.frac;
    assign res_ovf   = out_q.ovf;
    assign res_unf   = out_q.unf;

    // cycles since reset, saturating, for history-based checks
    logic [1:0] live_cnt;
    always_ff @(posedge clk) begin
        if (rst)                 live_cnt <= '0;
        else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
    end

    // R7
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (live_cnt == 2'd3) |-> (res_valid == $past(in_valid, 3)));

    // R1
    sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
        (live_cnt == 2'd3 && res_valid) |-> (res_sign == $past(op_a[WORD_W-1] ^ op_b[WORD_W-1], 3)));

    // R5
    unf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        res_unf |-> (res_exp == '0 && res_frac == '0 && !res_ovf));

    // R6
    ovf_sat_chk: assert property (@(posedge clk) disable iff (rst)
        res_ovf |-> (res_exp == '1 && res_frac == '0 && !res_unf));

    // R4
    exp_range_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ovf && !res_unf) |-> (res_exp != '0 && res_exp != '1));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!res_valid && !res_ovf && !res_unf && res_exp == '0));
endmodule

// File: tb/tb_fpm_top.sv
module tb_fpm_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        res_valid, res_sign, res_ovf, res_unf;
    logic [7:0]  res_exp;
    logic [46:0] res_frac;

    always #2.5 clk = ~clk;

    fpm_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .res_valid(res_valid), .res_sign(res_sign), .res_exp(res_exp),
        .res_frac(res_frac), .res_ovf(res_ovf), .res_unf(res_unf)
    );

    typedef struct {
        bit          v;
        bit          s;
        int          e;
        logic [46:0] f;
        bit          o;
        bit          u;
        bit          sh;
    } expect_t;

    expect_t q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    bit [31:0] rs = 32'h1234_5678;

    function automatic expect_t model(bit v, logic [31:0] a, logic [31:0] b);
        expect_t x;
        longint ma, mb, pr;
        logic [47:0] p;
        x.v = v;
        x.s = a[31] ^ b[31];
        ma = longint'({1'b1, a[22:0]});
        mb = longint'({1'b1, b[22:0]});
        pr = ma * mb;
        p = pr[47:0];
        x.e = int'(a[30:23]) + int'(b[30:23]) - 127;
        x.sh = p[47];
        if (p[47]) begin
            x.e = x.e + 1;
            x.f = p[46:0];
        end else begin
            x.f = {p[45:0], 1'b0};
        end
        x.o = 0;
        x.u = 0;
        if (x.e < 1) begin
            x.u = 1; x.e = 0; x.f = '0;
        end else if (x.e > 254) begin
            x.o = 1; x.e = 255; x.f = '0;
        end
        return x;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic compare(expect_t x);
        if (!x.v) begin
            chk(res_valid == 1'b0, "R7 bubble", longint'(res_valid), 0);
        end else begin
            chk(res_valid == 1'b1, "R7 valid", longint'(res_valid), 1);
            chk(res_sign == x.s, "R1 sign", longint'(res_sign), longint'(x.s));
            chk(int'(res_exp) == x.e, x.sh ? "R3/R4 exponent" : "R2/R4 exponent",
                longint'(res_exp), longint'(x.e));
            chk(res_frac == x.f, x.sh ? "R3/R9 fraction" : "R2/R9 fraction",
                longint'(res_frac), longint'(x.f));
            chk(res_ovf == x.o, "R6 overflow flag", longint'(res_ovf), longint'(x.o));
            chk(res_unf == x.u, "R5 underflow flag", longint'(res_unf), longint'(x.u));
        end
    endtask

    task automatic step(bit v, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        in_valid = v;
        op_a = a;
        op_b = b;
        q.push_back(model(v, a, b));
        @(posedge clk);
        #1;
        if (q.size() == 3) compare(q.pop_front());
    endtask

    function automatic logic [31:0] rnd_operand();
        bit [31:0] e;
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        e = 1 + (rs % 254);
        return {rs[31], e[7:0], rs[22:0]};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        // R8: drive a valid pair during reset; outputs must stay cleared
        in_valid = 1'b1;
        op_a = 32'h3F80_0000;
        op_b = 32'h3F80_0000;
        repeat (4) @(posedge clk);
        #1;
        chk(res_valid == 0, "R8 valid", longint'(res_valid), 0);
        chk(res_sign == 0 && res_exp == 0, "R8 sign/exp", longint'(res_exp), 0);
        chk(res_frac == 0, "R8 frac", longint'(res_frac), 0);
        chk(res_ovf == 0 && res_unf == 0, "R8 flags", longint'({res_ovf, res_unf}), 0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;

        // R2: 1.0 * 1.0, no shift
        step(1, 32'h3F80_0000, 32'h3F80_0000);
        // R3: 1.5 * 1.5 shifts
        step(1, 32'h3FC0_0000, 32'h3FC0_0000);
        // R1 R3: 40 * -7.5
        step(1, 32'h4220_0000, 32'hC0F0_0000);
        step(0, 32'h0, 32'h0);
        // R9: all-ones fractions, every product bit kept
        step(1, 32'h3FFF_FFFF, 32'hBFFF_FFFF);
        step(1, 32'h3F80_0001, 32'h3F80_0001);
        // R4 boundary: sum 0, shift lifts to 1
        step(1, 32'h1FC0_0000, 32'h2040_0000);
        // R5: sum 0 without shift
        step(1, 32'h1F80_0000, 32'h2000_0000);
        // R5: deepest underflow
        step(1, 32'h0080_0000, 32'h8080_0000);
        // R4 boundary: 254 exactly
        step(1, 32'h3F80_0000, 32'h7F00_0000);
        // R6: 254 plus shift
        step(1, 32'h3FC0_0000, 32'h7F40_0000);
        // R6: largest overflow
        step(1, 32'h7F7F_FFFF, 32'hFF7F_FFFF);
        step(0, 32'h3FC0_0000, 32'h7F40_0000);
        step(0, 32'h0, 32'h0);

        // R7: back-to-back random stream with sparse bubbles
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            a = rnd_operand();
            b = rnd_operand();
            step((i % 7) != 3, a, b);
        end
        for (int i = 0; i < 4; i++) step(0, 32'h0, 32'h0);
        finish_run();
    end
endmodule